// File: doc/BRIEF.md
# Serial PHY Management Master

This block is a bus-side controller for the two-wire serial management link used to reach the configuration and status registers of an external Ethernet PHY. Software programs a clock divider, the target PHY and register addresses and, for a write, a 16-bit data word. Setting a command bit then starts one management frame. The block produces the management clock, drives the data line during the host-owned part of the frame, and releases it whenever the PHY is expected to drive.

Software follows progress through a busy flag in the status register. After a read, the returned 16-bit word can be fetched from the receive-data register once busy has cleared. A command bit starts a frame only when it goes from 0 to 1, so software clears the command register before it issues the next command. The scan command is a stub: while its bit is set, the status register shows busy and invalid, and the management line stays idle.

Top module: `mgmt_serial_master`

## Requirements
- R1: Registers are selected by `reg_sel`: 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data, 5 status. Reads return data one cycle after the select is applied. Mode keeps bits 7:1 (the divider; bit 0 always reads 0) and bit 8 (preamble off). Address keeps the PHY number in bits 4:0 and the register number in bits 12:8. Transmit data keeps bits 15:0. All other bits read 0.
- R2: MDC toggles every max(D,2)/2 system clocks, where D is the stored divider. This makes an odd divider act as the next lower even value, and a divider of 0 act as 2.
- R3: Command bit 0 is scan, bit 1 is read and bit 2 is write. A frame starts only on a 0-to-1 change of bit 1 or bit 2 while the block is idle. A bit held high does not start another frame, and a rising edge during a frame is dropped.
- R4: Status bit 1 (busy) reads 1 from the first cycle after the command write until the frame's last MDC rising edge, and reads 0 afterwards. MDIO is driven only while a frame is running.
- R5: A write frame is sent MSB first, bit by bit on MDC falling edges: start 01, opcode 01, 5-bit PHY, 5-bit register, turnaround 10, then 16 data bits.
- R6: With mode bit 8 clear, the frame is preceded by 32 ones. With it set, the frame begins directly with the start bits.
- R7: A read frame uses opcode 10. MDIO is released for both turnaround bits and all 16 data bits. Data is sampled on MDC rising edges, MSB first, and shows in the receive-data register bits 15:0 once busy has cleared. That register changes at no other time.
- R8: When read and write rise in the same command write, a read frame is performed.
- R9: While command bit 0 is set, status reads busy (bit 1) and invalid (bit 2), and MDIO is never driven.
- R10: After reset all registers read 0, status bit 0 (link fail) always reads 0, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register select |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable (1 = drive) |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
A PHY model on the bench decodes each frame bit by bit and answers reads with a word derived from the addresses. A scoreboard compares each frame against what the command sequence predicts. Writes and reads are run with and without the preamble and with unlike addresses, so a wrong opcode, a swapped field, a missing turnaround release or a misaligned sample all show up. Odd, zero and large dividers are timed on MDC to separate rounding from the minimum clamp. Held, overlapping and combined commands, plus the scan stub, show whether start detection is edge-based, is ignored while busy, and gives read priority.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_ADDR = 3'd2,
    SEL_TXD  = 3'd3,
    SEL_RXD  = 3'd4,
    SEL_STAT = 3'd5
  } reg_sel_e;

  localparam int NOPRE_BIT = 8;
  localparam int CMD_SCAN  = 0;
  localparam int CMD_READ  = 1;
  localparam int CMD_WRITE = 2;
  localparam int ST_LINK   = 0;
  localparam int ST_BUSY   = 1;
  localparam int ST_INVAL  = 2;
  localparam int REG_FLD_LSB = 8;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;
endpackage

// File: rtl/mdm_mdc_gen.sv
module mdm_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt;
  logic             tick;

  always_comb begin
    half     = (div < DIV_W'(2)) ? DIV_W'(1) : (div >> 1);
    tick     = (cnt >= half - DIV_W'(1));
    rise_stb = tick & ~mdc;
    fall_stb = tick & mdc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdm_engine.sv
module mdm_engine
  import mdm_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic              no_pre,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HDR_W   = 4 + 2 * ADDR_W + 2;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int TOT_W   = PRE_LEN + FRAME_W;
  localparam int CNT_W   = $clog2(TOT_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [TOT_W-1:0]   load_val;
  logic [TOT_W-1:0]   shift;
  logic [CNT_W-1:0]   bits_left;
  logic [DATA_W-1:0]  rx_shift;
  logic               rd_mode;

  always_comb begin
    frame = {2'b01, (is_read ? OPC_RD : OPC_WR), phy, regad, 2'b10,
             (is_read ? DATA_W'(0) : wdata)};
    load_val = no_pre ? {frame, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, frame};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      shift     <= '0;
      bits_left <= '0;
      rx_shift  <= '0;
      rd_mode   <= 1'b0;
      mdio_o    <= 1'b0;
      mdio_oe   <= 1'b0;
      rd_data   <= '0;
    end else if (!active) begin
      if (start) begin
        active    <= 1'b1;
        shift     <= load_val;
        bits_left <= no_pre ? CNT_W'(FRAME_W) : CNT_W'(TOT_W);
        rd_mode   <= is_read;
        rx_shift  <= '0;
      end
    end else begin
      if (fall_stb && bits_left != '0) begin
        mdio_o    <= shift[TOT_W-1];
        shift     <= shift << 1;
        mdio_oe   <= !(rd_mode && bits_left <= CNT_W'(DATA_W + 2));
        bits_left <= bits_left - CNT_W'(1);
      end
      if (rise_stb && rd_mode && bits_left < CNT_W'(DATA_W))
        rx_shift <= {rx_shift[DATA_W-2:0], mdio_i};
      if (rise_stb && bits_left == '0) begin
        active  <= 1'b0;
        mdio_oe <= 1'b0;
        if (rd_mode)
          rd_data <= {rx_shift[DATA_W-2:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        reg_sel,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              eng_active,
  input  logic [DATA_W-1:0] rx_word,
  output logic [DIV_W-1:0]  div,
  output logic              no_pre,
  output logic [ADDR_W-1:0] phy,
  output logic [ADDR_W-1:0] regad,
  output logic [DATA_W-1:0] txd,
  output logic              start,
  output logic              start_is_read
);
  logic [2:0]       cmd_q;
  logic [2:0]       cmd_prev;
  logic [2:0]       cmd_rise;
  logic [2:0]       status;
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    cmd_rise      = cmd_q & ~cmd_prev;
    start         = (cmd_rise[CMD_READ] | cmd_rise[CMD_WRITE]) & ~eng_active;
    start_is_read = cmd_rise[CMD_READ];
    status            = '0;
    status[ST_LINK]   = 1'b0;
    status[ST_BUSY]   = eng_active | start | cmd_q[CMD_SCAN];
    status[ST_INVAL]  = cmd_q[CMD_SCAN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div      <= '0;
      no_pre   <= 1'b0;
      phy      <= '0;
      regad    <= '0;
      txd      <= '0;
      cmd_q    <= '0;
      cmd_prev <= '0;
    end else begin
      cmd_prev <= cmd_q;
      if (reg_we) begin
        case (reg_sel)
          SEL_MODE: begin
            div    <= {reg_wdata[DIV_W-1:1], 1'b0};
            no_pre <= reg_wdata[NOPRE_BIT];
          end
          SEL_CMD:  cmd_q <= reg_wdata[2:0];
          SEL_ADDR: begin
            phy   <= reg_wdata[ADDR_W-1:0];
            regad <= reg_wdata[REG_FLD_LSB +: ADDR_W];
          end
          SEL_TXD:  txd <= reg_wdata[DATA_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_sel)
      SEL_MODE: begin
        rd_mux[DIV_W-1:0]   = div;
        rd_mux[NOPRE_BIT]   = no_pre;
      end
      SEL_CMD:  rd_mux[2:0] = cmd_q;
      SEL_ADDR: begin
        rd_mux[ADDR_W-1:0]              = phy;
        rd_mux[REG_FLD_LSB +: ADDR_W]   = regad;
      end
      SEL_TXD:  rd_mux[DATA_W-1:0] = txd;
      SEL_RXD:  rd_mux[DATA_W-1:0] = rx_word;
      SEL_STAT: rd_mux[2:0] = status;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master #(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int REG_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       reg_sel,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [DIV_W-1:0]  div;
  logic              no_pre;
  logic [ADDR_W-1:0] phy;
  logic [ADDR_W-1:0] regad;
  logic [DATA_W-1:0] txd;
  logic              start;
  logic              start_is_read;
  logic              eng_busy;
  logic [DATA_W-1:0] rx_word;
  logic              rise_stb;
  logic              fall_stb;

  mdm_regs #(
    .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_active(eng_busy), .rx_word(rx_word),
    .div(div), .no_pre(no_pre), .phy(phy), .regad(regad), .txd(txd),
    .start(start), .start_is_read(start_is_read)
  );

  mdm_mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .div(div),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdm_engine #(
    .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_eng (
    .clk(clk), .rst(rst),
    .start(start), .is_read(start_is_read), .no_pre(no_pre),
    .phy(phy), .regad(regad), .wdata(txd),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .active(eng_busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rx_word)
  );
endmodule

// File: rtl/mgmt_serial_master_chk.sv
module mgmt_serial_master_chk #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              eng_busy,
  input logic [DATA_W-1:0] rx_word
);
  localparam int MAX_HALF = (1 << (DIV_W - 1)) - 1;
  logic [DIV_W:0] stall_cnt;

  always_ff @(posedge clk) begin
    if (rst || mdc != $past(mdc)) stall_cnt <= '0;
    else                          stall_cnt <= stall_cnt + 1'b1;
  end

  // R2: MDC never stays at one level longer than the largest half period
  p_mdc_toggles_r2: assert property (@(posedge clk) disable iff (rst)
    stall_cnt <= (DIV_W+1)'(MAX_HALF));

  // R5: data output only moves together with an MDC falling edge
  p_out_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));

  // R4: line is driven only while a frame is running
  p_oe_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> eng_busy);

  // R7: received word changes only when a frame ends
  p_rx_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word) |-> $fell(eng_busy));

  // R4: the frame ends on an MDC rising edge
  p_end_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_busy) |-> $rose(mdc));
endmodule

bind mgmt_serial_master mgmt_serial_master_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .eng_busy(eng_busy), .rx_word(rx_word)
);

// File: tb/mgmt_serial_master_bench.sv
module mgmt_serial_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0, errors = 0, frames = 0, oe_cycles = 0, cyc = 0;
  bit finished = 0;

  typedef struct {
    bit          rd;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] data;
    int          pre;
  } xact_t;
  xact_t exp_q[$];

  mgmt_serial_master u_mgmt_serial_master (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mdio_oe) oe_cycles <= oe_cycles + 1;
  end

  function automatic logic [15:0] phy_reply(logic [4:0] p, logic [4:0] r);
    return 16'h5A00 ^ {p, r, 6'h15};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd5, s);
      if (!s[1]) return;
    end
    check(0, "R4 busy never cleared", s, 0);
  endtask

  // driver: pushes the expected frame, then runs it through the registers
  task automatic do_xact(bit is_rd, logic [4:0] p, logic [4:0] r, logic [15:0] d, bit nopre);
    logic [31:0] s;
    xact_t x;
    x.rd = is_rd; x.phy = p; x.ra = r; x.pre = nopre ? 0 : 32;
    x.data = is_rd ? phy_reply(p, r) : d;
    exp_q.push_back(x);
    wr(3'd2, {19'd0, r, 3'd0, p});
    wr(3'd3, {16'd0, d});
    wr(3'd1, is_rd ? 32'd2 : 32'd4);
    rd(3'd5, s);
    check(s[1] == 1'b1, "R4 busy after command", s, 32'h2);
    wait_idle();
    if (is_rd) begin
      rd(3'd4, s);
      check(s == {16'd0, phy_reply(p, r)}, "R7 read data", s, {16'd0, phy_reply(p, r)});
    end
    wr(3'd1, 32'd0);
  endtask

  // monitor: PHY model decoding frames and comparing with the scoreboard
  initial begin
    forever begin
      int pre;
      logic [1:0] op, ta;
      logic [4:0] p, r;
      logic [15:0] d;
      logic b;
      xact_t x;
      @(posedge mdc); @(negedge clk);
      if (!mdio_oe) continue;
      pre = 0; b = mdio_o;
      while (b == 1'b1) begin
        pre++; @(posedge mdc); @(negedge clk); b = mdio_o;
      end
      @(posedge mdc); @(negedge clk); b = mdio_o;
      for (int i = 0; i < 2; i++) begin @(posedge mdc); @(negedge clk); op = {op[0], mdio_o}; end
      for (int i = 0; i < 5; i++) begin @(posedge mdc); @(negedge clk); p = {p[3:0], mdio_o}; end
      for (int i = 0; i < 5; i++) begin @(posedge mdc); @(negedge clk); r = {r[3:0], mdio_o}; end
      if (op == 2'b10) begin
        d = phy_reply(p, r);
        @(negedge mdc); @(posedge mdc); @(negedge clk);
        check(!mdio_oe, "R7 released at turnaround 1", mdio_oe, 0);
        @(negedge mdc); mdio_i = 1'b0;
        @(posedge mdc); @(negedge clk);
        check(!mdio_oe, "R7 released at turnaround 2", mdio_oe, 0);
        for (int i = 15; i >= 0; i--) begin
          @(negedge mdc); mdio_i = d[i];
          @(posedge mdc);
        end
        @(negedge clk); mdio_i = 1'b1;
      end else begin
        for (int i = 0; i < 2; i++) begin @(posedge mdc); @(negedge clk); ta = {ta[0], mdio_o}; end
        for (int i = 0; i < 16; i++) begin @(posedge mdc); @(negedge clk); d = {d[14:0], mdio_o}; end
        check(ta == 2'b10, "R5 turnaround", ta, 2'b10);
      end
      frames++;
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected frame", {op, p, r}, 0);
      end else begin
        x = exp_q.pop_front();
        check(b == 1'b1 && op == (x.rd ? 2'b10 : 2'b01) && p == x.phy && r == x.ra,
              x.rd ? "R7 R8 read header" : "R5 write header",
              {b, op, p, r}, {1'b1, (x.rd ? 2'b10 : 2'b01), x.phy, x.ra});
        check(pre == x.pre, "R6 preamble length", pre, x.pre);
        if (!x.rd) check(d == x.data, "R5 write data", d, x.data);
      end
    end
  end

  task automatic measure_half(logic [31:0] mode, int exp_half, string req);
    int t0, t1;
    wr(3'd0, mode);
    repeat (3) @(posedge mdc);
    @(posedge mdc); t0 = cyc;
    @(negedge mdc); t1 = cyc;
    check(t1 - t0 == exp_half, req, t1 - t0, exp_half);
  endtask

  initial begin
    logic [31:0] v;
    int f0, o0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    rd(3'd0, v); check(v == 0, "R10 mode after reset", v, 0);
    rd(3'd5, v); check(v == 0, "R10 status after reset", v, 0);
    rd(3'd4, v); check(v == 0, "R10 rx after reset", v, 0);
    check(mdio_oe == 0, "R10 line released", mdio_oe, 0);
    // R1 field masking
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check(v == 32'h1F1F, "R1 address fields", v, 32'h1F1F);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); check(v == 32'hFFFF, "R1 tx data width", v, 32'hFFFF);
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check(v == 32'h1FE, "R1 mode fields", v, 32'h1FE);
    // R2 divider
    measure_half(32'd0, 1, "R2 zero divider clamps");
    measure_half(32'd4, 2, "R2 divider 4");
    measure_half(32'd7, 3, "R2 odd divider");
    rd(3'd0, v); check(v == 32'd6, "R2 bit0 forced low", v, 6);
    measure_half(32'd10, 5, "R2 divider 10");
    wr(3'd0, 32'd4);
    // R5 R6 R7 frames with preamble
    do_xact(0, 5'h01, 5'h00, 16'hBEEF, 0);
    do_xact(1, 5'h1E, 5'h11, 16'h0000, 0);
    do_xact(0, 5'h10, 5'h1F, 16'h8001, 0);
    // R6 without preamble
    wr(3'd0, 32'h104);
    do_xact(0, 5'h0A, 5'h05, 16'h1234, 1);
    do_xact(1, 5'h03, 5'h1C, 16'h0000, 1);
    wr(3'd0, 32'd4);
    // R3 held command starts nothing more
    exp_q.push_back('{1'b0, 5'h02, 5'h03, 16'hA5A5, 32});
    wr(3'd2, 32'h0302); wr(3'd3, 32'hA5A5); wr(3'd1, 32'd4);
    wait_idle(); f0 = frames;
    repeat (400) @(posedge clk); @(negedge clk);
    check(frames == f0, "R3 held bit no restart", frames, f0);
    rd(3'd5, v); check(v == 0, "R3 idle while held", v, 0);
    // R3 rising edge while busy is dropped
    wr(3'd1, 32'd0);
    exp_q.push_back('{1'b0, 5'h02, 5'h03, 16'hA5A5, 32});
    wr(3'd1, 32'd4); wr(3'd1, 32'd0); wr(3'd1, 32'd2);
    wait_idle();
    repeat (400) @(posedge clk); @(negedge clk);
    check(frames == f0 + 1, "R3 edge during frame dropped", frames, f0 + 1);
    wr(3'd1, 32'd0);
    // R8 read wins
    exp_q.push_back('{1'b1, 5'h07, 5'h09, phy_reply(5'h07, 5'h09), 32});
    wr(3'd2, 32'h0907); wr(3'd1, 32'd6);
    wait_idle();
    rd(3'd4, v); check(v == {16'd0, phy_reply(5'h07, 5'h09)}, "R8 combined gives read", v, {16'd0, phy_reply(5'h07, 5'h09)});
    wr(3'd1, 32'd0);
    // R9 scan stub
    f0 = frames; o0 = oe_cycles;
    wr(3'd1, 32'd1);
    rd(3'd5, v); check(v == 32'h6, "R9 scan busy invalid R10 link 0", v, 6);
    repeat (400) @(posedge clk); @(negedge clk);
    check(oe_cycles == o0 && frames == f0, "R9 line idle during scan", oe_cycles, o0);
    wr(3'd1, 32'd0);
    rd(3'd5, v); check(v == 0, "R9 scan cleared", v, 0);
    repeat (20) @(posedge clk); @(negedge clk);
    check(exp_q.size() == 0, "R5 all frames seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule